// File: doc/BRIEF.md
# GMII Transmit Packet Delimiter Inserter

This block sits between a byte-wide GMII-style transmit source and a serial link MAC. Each clock it samples an enable, an error flag and a data byte. It emits one byte per clock together with a control flag that tells the MAC whether the byte is a control character or payload. The source raises the enable two cycles ahead of its first real byte. The block turns the second of those lead-in slots into a start character, passes the payload through unchanged, and closes the packet with a terminate character followed by a carrier-extend character once the enable drops. Payload bytes flagged as errored leave the block as the invalid-character code. Slots that carry no packet leave as the idle code.

The stream has no ready signal. The enable is the valid qualifier, and every cycle produces exactly one output symbol, so the block applies no back-pressure. A source that needs pacing reads four fill flags. The block decodes these from a status word supplied by the downstream buffer. The source must hold off whenever those flags say the buffer is full. Payload leaves a fixed number of cycles after it enters, with no stalls and no reordering.

Top module: `gmii_delim_tx`

## Requirements
- R1: A synchronous active-high reset, sampled at a rising edge, puts the idle symbol (control flag 1, byte 0x07) on the output after that edge. A packet in progress is abandoned without a terminate pair.
- R2: The first sampled-high enable slot of a run leaves as idle. The second leaves as the start symbol (control flag 1, byte 0xFB). The start symbol is always followed by payload, an error symbol or a terminate symbol.
- R3: From the third sampled-high slot on, each data byte leaves unchanged with control flag 0, in order. A byte sampled at rising edge k is on the output after edge k+2. Payload bytes equal to a control code still carry control flag 0.
- R4: The first low enable sample after a run of at least two high samples leaves as the terminate symbol (flag 1, 0xFD). The slot after it always leaves as carrier-extend (flag 1, 0xF7).
- R5: A payload slot with the error input high leaves as the error symbol (flag 1, 0xFE). The error input has no effect in lead-in and idle slots.
- R6: A high enable run of only one sample produces no start and no terminate symbol; every slot stays idle.
- R7: When the enable rises again in the slot right after a terminate slot, that slot still carries carrier-extend. The next slot carries the start symbol for the new packet.
- R8: Slots outside any packet leave as idle (flag 1, 0x07). The control flag is never set together with any byte other than 0x07, 0xFB, 0xFD, 0xF7 or 0xFE.
- R9: The status flags follow the downstream status word combinationally: bit 3 drives empty, bit 2 almost empty, bit 1 full, bit 0 almost full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable, raised two cycles before the first payload byte |
| tx_err | input | 1 | Marks the current payload byte as errored |
| tx_data | input | 8 | Transmit data byte |
| buf_level | input | 4 | Fill-status word from the downstream buffer |
| lnk_data | output | 8 | Byte toward the link MAC |
| lnk_ctrl | output | 1 | High when lnk_data is a control character |
| buf_empty | output | 1 | Downstream buffer empty |
| buf_low | output | 1 | Downstream buffer almost empty |
| buf_full | output | 1 | Downstream buffer full |
| buf_high | output | 1 | Downstream buffer almost full |

## Verification
The assertions watch only the output symbol stream. They assume the output register starts from a reset, so the initial reset is held for several edges before any property is checked. They also rely on the enable being a clean sampled level, since a terminate is always followed by carrier-extend regardless of the next input. The directed stimulus changes inputs only on falling edges, keeps every packet separated by idle slots unless a test deliberately re-raises the enable right after a fall, and returns the block to idle before each new scenario starts.

// File: rtl/gdt_pkg.sv
package gdt_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] K_IDLE  = 8'h07;
  localparam logic [BYTE_W-1:0] K_START = 8'hFB;
  localparam logic [BYTE_W-1:0] K_TERM  = 8'hFD;
  localparam logic [BYTE_W-1:0] K_EXT   = 8'hF7;
  localparam logic [BYTE_W-1:0] K_ERR   = 8'hFE;

  // Role of one transmit slot, decided once at the input
  typedef enum logic [2:0] {
    SL_IDLE  = 3'd0,
    SL_LEAD  = 3'd1,
    SL_START = 3'd2,
    SL_DATA  = 3'd3,
    SL_BAD   = 3'd4,
    SL_TERM  = 3'd5,
    SL_EXT   = 3'd6
  } slot_kind_t;

  typedef struct packed {
    slot_kind_t           kind;
    logic [BYTE_W-1:0]    byte_v;
  } slot_t;

  localparam slot_t IDLE_SLOT = '{kind: SL_IDLE, byte_v: '0};

endpackage

// File: rtl/gdt_classify.sv
module gdt_classify
  import gdt_pkg::*;
#(
  parameter int LEAD_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              err_i,
  input  logic [BYTE_W-1:0] data_i,
  output slot_t             slot_o
);

  localparam int CNT_W = $clog2(LEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LEAD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LEAD_CYCLES - 1);

  logic [CNT_W-1:0] run_q;
  logic             term_q;
  slot_kind_t       kind_d;

  // Slot role from the run position and the previous slot
  always_comb begin
    if (term_q) begin
      kind_d = SL_EXT;
    end else if (en_i) begin
      if (run_q < CNT_LAST)       kind_d = SL_LEAD;
      else if (run_q == CNT_LAST) kind_d = SL_START;
      else if (err_i)             kind_d = SL_BAD;
      else                        kind_d = SL_DATA;
    end else begin
      kind_d = (run_q == CNT_MAX) ? SL_TERM : SL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      term_q <= 1'b0;
      slot_o <= IDLE_SLOT;
    end else begin
      if (!en_i)                run_q <= '0;
      else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
      term_q <= (kind_d == SL_TERM);
      slot_o <= '{kind: kind_d, byte_v: data_i};
    end
  end

endmodule

// File: rtl/gdt_skew.sv
module gdt_skew
  import gdt_pkg::*;
#(
  parameter int STAGES = 1
) (
  input  logic  clk,
  input  logic  rst,
  input  slot_t slot_i,
  output slot_t slot_o
);

  generate
    if (STAGES == 0) begin : g_wire
      assign slot_o = slot_i;
    end else begin : g_chain
      slot_t q [STAGES];
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
          always_ff @(posedge clk) begin
            if (rst) q[g] <= IDLE_SLOT;
            else     q[g] <= slot_i;
          end
        end else begin : g_body
          always_ff @(posedge clk) begin
            if (rst) q[g] <= IDLE_SLOT;
            else     q[g] <= q[g-1];
          end
        end
      end
      assign slot_o = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/gdt_encode.sv
module gdt_encode
  import gdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  slot_t             slot_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              ctrl_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= K_IDLE;
      ctrl_o <= 1'b1;
    end else begin
      ctrl_o <= 1'b1;
      unique case (slot_i.kind)
        SL_START: data_o <= K_START;
        SL_DATA: begin
          data_o <= slot_i.byte_v;
          ctrl_o <= 1'b0;
        end
        SL_BAD:  data_o <= K_ERR;
        SL_TERM: data_o <= K_TERM;
        SL_EXT:  data_o <= K_EXT;
        default: data_o <= K_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gdt_level_map.sv
module gdt_level_map #(
  parameter int LVL_W = 4
) (
  input  logic [LVL_W-1:0] level_i,
  output logic             empty_o,
  output logic             low_o,
  output logic             full_o,
  output logic             high_o
);

  assign empty_o = level_i[3];
  assign low_o   = level_i[2];
  assign full_o  = level_i[1];
  assign high_o  = level_i[0];

endmodule

// File: rtl/gmii_delim_tx.sv
module gmii_delim_tx
  import gdt_pkg::*;
#(
  parameter int LEAD_CYCLES = 2,
  parameter int SKEW_STAGES = 1,
  parameter int LVL_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              tx_err,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic [LVL_W-1:0]  buf_level,
  output logic [BYTE_W-1:0] lnk_data,
  output logic              lnk_ctrl,
  output logic              buf_empty,
  output logic              buf_low,
  output logic              buf_full,
  output logic              buf_high
);

  slot_t cls_slot;
  slot_t dly_slot;

  gdt_classify #(.LEAD_CYCLES(LEAD_CYCLES)) u_cls (
    .clk    (clk),
    .rst    (rst),
    .en_i   (tx_en),
    .err_i  (tx_err),
    .data_i (tx_data),
    .slot_o (cls_slot)
  );

  gdt_skew #(.STAGES(SKEW_STAGES)) u_skew (
    .clk    (clk),
    .rst    (rst),
    .slot_i (cls_slot),
    .slot_o (dly_slot)
  );

  gdt_encode u_enc (
    .clk    (clk),
    .rst    (rst),
    .slot_i (dly_slot),
    .data_o (lnk_data),
    .ctrl_o (lnk_ctrl)
  );

  gdt_level_map #(.LVL_W(LVL_W)) u_lvl (
    .level_i (buf_level),
    .empty_o (buf_empty),
    .low_o   (buf_low),
    .full_o  (buf_full),
    .high_o  (buf_high)
  );

endmodule

// File: rtl/gmii_delim_tx_chk.sv
module gmii_delim_tx_chk
  import gdt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] lnk_data,
  input logic              lnk_ctrl
);

  logic is_s, is_t, is_r, is_v;
  assign is_s = lnk_ctrl && (lnk_data == K_START);
  assign is_t = lnk_ctrl && (lnk_data == K_TERM);
  assign is_r = lnk_ctrl && (lnk_data == K_EXT);
  assign is_v = lnk_ctrl && (lnk_data == K_ERR);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lnk_ctrl && lnk_data == K_IDLE));

  assert_start_then_body_R2: assert property (@(posedge clk) disable iff (rst)
    is_s |=> (!lnk_ctrl || is_v || is_t));

  assert_payload_follows_R3: assert property (@(posedge clk) disable iff (rst)
    !lnk_ctrl |-> $past(!lnk_ctrl || is_s || is_v));

  assert_term_then_ext_R4: assert property (@(posedge clk) disable iff (rst)
    is_t |=> is_r);

  assert_ext_needs_term_R4: assert property (@(posedge clk) disable iff (rst)
    is_r |-> $past(is_t));

  assert_known_code_R8: assert property (@(posedge clk) disable iff (rst)
    lnk_ctrl |-> (lnk_data == K_IDLE || is_s || is_t || is_r || is_v));

endmodule

bind gmii_delim_tx gmii_delim_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .lnk_data (lnk_data),
  .lnk_ctrl (lnk_ctrl)
);

// File: tb/gmii_delim_tx_test.sv
`timescale 1ns/1ps
module gmii_delim_tx_test;

  localparam int NS = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       tx_err = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [3:0] buf_level = 4'h0;
  logic [7:0] lnk_data;
  logic       lnk_ctrl;
  logic       buf_empty, buf_low, buf_full, buf_high;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic       s_en  [NS];
  logic       s_err [NS];
  logic [7:0] s_d   [NS];
  logic [7:0] e_d   [NS];
  logic       e_c   [NS];
  logic [7:0] o_d   [NS];
  logic       o_c   [NS];

  always #10 clk = ~clk;

  gmii_delim_tx uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_err(tx_err), .tx_data(tx_data),
    .buf_level(buf_level), .lnk_data(lnk_data), .lnk_ctrl(lnk_ctrl),
    .buf_empty(buf_empty), .buf_low(buf_low), .buf_full(buf_full), .buf_high(buf_high)
  );

  task automatic check(string req, string what, logic [8:0] got, logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual ctrl/data %0b/%02h expected %0b/%02h",
               req, what, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic clear_slots();
    for (int i = 0; i < NS; i++) begin
      s_en[i] = 1'b0; s_err[i] = 1'b0; s_d[i] = 8'h00;
      e_d[i] = 8'h07; e_c[i] = 1'b1;
    end
  endtask

  task automatic set_slot(int i, logic en, logic err, logic [7:0] d, logic ec, logic [7:0] ed);
    s_en[i] = en; s_err[i] = err; s_d[i] = d; e_c[i] = ec; e_d[i] = ed;
  endtask

  // Drives n slots; the symbol for slot i is observed three falling edges later
  task automatic play(string req, int n);
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      o_d[i] = lnk_data; o_c[i] = lnk_ctrl;
      if (i < n) begin
        tx_en = s_en[i]; tx_err = s_err[i]; tx_data = s_d[i];
      end else begin
        tx_en = 1'b0; tx_err = 1'b0; tx_data = 8'h00;
      end
    end
    for (int i = 0; i < n; i++)
      check(req, $sformatf("slot %0d", i), {o_c[i+3], o_d[i+3]}, {e_c[i], e_d[i]});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "after initial reset", {lnk_ctrl, lnk_data}, {1'b1, 8'h07});
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tx_en = 1'b1; tx_data = 8'h5A;
    end
    rst = 1'b1;
    @(negedge clk);
    check("R1", "reset mid packet", {lnk_ctrl, lnk_data}, {1'b1, 8'h07});
    rst = 1'b0; tx_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", "no terminate after reset", {lnk_ctrl, lnk_data}, {1'b1, 8'h07});
    end
  endtask

  task automatic t_basic();
    clear_slots();
    set_slot(0, 1, 0, 8'hEE, 1, 8'h07);
    set_slot(1, 1, 0, 8'hEE, 1, 8'hFB);
    set_slot(2, 1, 0, 8'hA1, 0, 8'hA1);
    set_slot(3, 1, 0, 8'hB2, 0, 8'hB2);
    set_slot(4, 1, 0, 8'hC3, 0, 8'hC3);
    set_slot(5, 0, 0, 8'h00, 1, 8'hFD);
    set_slot(6, 0, 0, 8'h00, 1, 8'hF7);
    play("R2 R3 R4 R8", 9);
  endtask

  task automatic t_error();
    clear_slots();
    set_slot(0, 1, 1, 8'h33, 1, 8'h07);
    set_slot(1, 1, 0, 8'h00, 1, 8'hFB);
    set_slot(2, 1, 0, 8'h10, 0, 8'h10);
    set_slot(3, 1, 1, 8'h44, 1, 8'hFE);
    set_slot(4, 1, 0, 8'h20, 0, 8'h20);
    set_slot(5, 1, 0, 8'h30, 0, 8'h30);
    set_slot(6, 0, 0, 8'h00, 1, 8'hFD);
    set_slot(7, 0, 1, 8'h55, 1, 8'hF7);
    set_slot(8, 0, 1, 8'h66, 1, 8'h07);
    play("R5", 10);
  endtask

  task automatic t_short();
    clear_slots();
    set_slot(1, 1, 0, 8'h99, 1, 8'h07);
    set_slot(4, 1, 0, 8'h00, 1, 8'h07);
    set_slot(5, 1, 0, 8'h00, 1, 8'hFB);
    set_slot(6, 0, 0, 8'h00, 1, 8'hFD);
    set_slot(7, 0, 0, 8'h00, 1, 8'hF7);
    play("R6", 10);
  endtask

  task automatic t_backtoback();
    clear_slots();
    set_slot(0, 1, 0, 8'h00, 1, 8'h07);
    set_slot(1, 1, 0, 8'h00, 1, 8'hFB);
    set_slot(2, 1, 0, 8'h01, 0, 8'h01);
    set_slot(3, 1, 0, 8'h02, 0, 8'h02);
    set_slot(4, 0, 0, 8'h00, 1, 8'hFD);
    set_slot(5, 1, 0, 8'h00, 1, 8'hF7);
    set_slot(6, 1, 0, 8'h00, 1, 8'hFB);
    set_slot(7, 1, 0, 8'h03, 0, 8'h03);
    set_slot(8, 0, 0, 8'h00, 1, 8'hFD);
    set_slot(9, 0, 0, 8'h00, 1, 8'hF7);
    play("R7", 11);
  endtask

  task automatic t_transparent();
    clear_slots();
    set_slot(0, 1, 0, 8'h00, 1, 8'h07);
    set_slot(1, 1, 0, 8'h00, 1, 8'hFB);
    set_slot(2, 1, 0, 8'hFB, 0, 8'hFB);
    set_slot(3, 1, 0, 8'hFD, 0, 8'hFD);
    set_slot(4, 1, 0, 8'hF7, 0, 8'hF7);
    set_slot(5, 1, 0, 8'hFE, 0, 8'hFE);
    set_slot(6, 1, 0, 8'h07, 0, 8'h07);
    set_slot(7, 0, 0, 8'h00, 1, 8'hFD);
    set_slot(8, 0, 0, 8'h00, 1, 8'hF7);
    play("R3", 10);
  endtask

  task automatic t_status();
    logic [3:0] pats [6] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001, 4'b0000, 4'b1111};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      buf_level = pats[i];
      #1;
      check("R9", $sformatf("flags for %04b", pats[i]),
            {5'b0, buf_empty, buf_low, buf_full, buf_high}, {5'b0, pats[i]});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_basic();
    t_error();
    t_short();
    t_backtoback();
    t_transparent();
    t_status();
    finish_run();
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule